// File: doc/BRIEF.md
# Phase-Shifted Resonant Converter Gate Timer

This block generates the four gate patterns of a fixed-frequency half-bridge resonant converter that has a synchronous-rectifier output stage. It runs from a fast clock in which one tick is one unit of gate timing resolution. The two primary gates alternate, each for one half of the period minus a programmable dead time. The two secondary low-side gates share one programmable on-time that is normally longer than half the period, so both are on during overlap windows. The overlap that comes before each primary turn-off is advanced by a programmable phase shift. This stores enough inductor current to give zero-voltage turn-on at the next primary edge.

The block samples its period, dead-time, on-time and phase-shift inputs only at a period start. It clamps them into a legal pattern and then walks a state machine through each half-period. Each half has four states, and the second half mirrors the first:
- **PRE**: both secondaries on.
- **RECT**: one secondary off.
- **POST**: both secondaries on again, primary still on.
- **DEAD**: primaries off, secondaries on.

The states are `ST_IDLE`, `ST_H1_PRE`, `ST_H1_RECT`, `ST_H1_POST`, `ST_H1_DEAD`, `ST_H2_PRE`, `ST_H2_RECT`, `ST_H2_POST` and `ST_H2_DEAD`. Each transition is selected by the tick count against the latched boundaries:
- IDLE leads to H1_PRE, or straight to H1_RECT when PRE is empty.
- In each half the order is PRE, then RECT, then POST (skipped when empty), then DEAD.
- H1_DEAD leads to H2_PRE.
- H2_DEAD leads to H1_PRE.
- Any state goes to IDLE when the block is disabled.

A one-tick strobe marks each period start. With the default setting of 200 ticks, a 1 ns tick gives 5 MHz switching.

Top module: `rgt_gate_timer`

## Requirements
- R1: While `rst_n` is low, or from the second rising edge after `en` is sampled low, all five outputs are low. When `en` is sampled high from idle, the tick counter restarts at 0, and tick 0 appears on the outputs after the second rising edge.
- R2: The half-period is H = floor(`period_i`/2), raised to at least 4. A period lasts 2H ticks, and `frame_o` is high exactly on tick 0 of each period.
- R3: `gate_pri_a_o` is high on ticks [0, H-d) and `gate_pri_b_o` on ticks [H, 2H-d). The two are never high together.
- R4: The effective dead time d is `dead_i` clamped into [1, H-2], so a programmed zero still gives a one-tick gap.
- R5: `gate_sec_b_o` is low only on ticks [H-s-W, H-s) of each period, where W = 2H-`son_i` is clamped into [1, H-d]. When `son_i` ≥ 2H, W is 1.
- R6: `gate_sec_a_o` is low only on ticks [2H-s-W, 2H-s), which is the R5 window delayed by H. The two secondary gates are never low together while running.
- R7: The effective phase shift s is `shift_i` clamped into [d, H-W]. The secondary off window therefore always lies inside the conduction interval of the matching primary gate.
- R8: Configuration inputs that change during a period have no effect until the next period start.
- R9: Within each half the states run PRE, RECT, POST, DEAD in that order. PRE and POST may be empty, RECT and DEAD are never empty, and the second half repeats the pattern with the roles of the two primaries and the two secondaries swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| period_i | input | CNT_W | Requested period in ticks |
| dead_i | input | CNT_W | Requested dead time in ticks |
| son_i | input | CNT_W | Shared secondary on-time in ticks |
| shift_i | input | CNT_W | Requested phase shift in ticks |
| gate_pri_a_o | output | 1 | First primary gate |
| gate_pri_b_o | output | 1 | Second primary gate |
| gate_sec_a_o | output | 1 | Secondary gate off in the second half |
| gate_sec_b_o | output | 1 | Secondary gate off in the first half |
| frame_o | output | 1 | Period-start strobe |

## Verification
A period start and a configuration change can land in the same cycle. The bench provokes this by changing all four settings in the middle of period 0. The scoreboard then expects period 0 to keep the old pattern and every later period to carry the new one, including a shorter or longer period length. Clamping and phase placement can also meet, because the R5 off window may start on tick 0 or end exactly where the dead time begins. Separate cases drive a zero dead time, a 0.5 duty and an oversized phase shift, and each tick is judged against the pattern the bench computes from the clamped values.

// File: rtl/rgt_pkg.sv
package rgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_H1_PRE,
        ST_H1_RECT,
        ST_H1_POST,
        ST_H1_DEAD,
        ST_H2_PRE,
        ST_H2_RECT,
        ST_H2_POST,
        ST_H2_DEAD
    } rgt_state_e;
endpackage

// File: rtl/rgt_cfg_limit.sv
module rgt_cfg_limit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] dead_i,
    input  logic [CNT_W-1:0] son_i,
    input  logic [CNT_W-1:0] shift_i,
    output logic [CNT_W-1:0] full_o,
    output logic [CNT_W-1:0] half_o,
    output logic [CNT_W-1:0] pa_end_o,
    output logic [CNT_W-1:0] win_lo_o,
    output logic [CNT_W-1:0] win_hi_o
);
    localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(4);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);

    logic [CNT_W-1:0] h, two_h, d, w, s;

    always_comb begin
        h = period_i >> 1;
        if (h < MIN_HALF) h = MIN_HALF;
        two_h = h << 1;
        d = dead_i;
        if (d < ONE) d = ONE;
        if (d > h - TWO) d = h - TWO;
        if (son_i >= two_h) w = ONE;
        else                w = two_h - son_i;
        if (w > h - d) w = h - d;
        s = shift_i;
        if (s < d) s = d;
        if (s > h - w) s = h - w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_o   <= '0;
            half_o   <= '0;
            pa_end_o <= '0;
            win_lo_o <= '0;
            win_hi_o <= '0;
        end else if (load_i) begin
            full_o   <= two_h;
            half_o   <= h;
            pa_end_o <= h - d;
            win_lo_o <= h - s - w;
            win_hi_o <= h - s;
        end
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> ($stable(full_o) && $stable(win_lo_o) && $stable(pa_end_o)));
    // R7
    win_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (win_lo_o < win_hi_o && win_hi_o <= pa_end_o && pa_end_o < half_o));
endmodule

// File: rtl/rgt_period_ctr.sv
module rgt_period_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] full_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             load_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign load_o = en && (!run_o || cnt_o == full_i - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
            run_o <= 1'b0;
        end else if (!en) begin
            cnt_o <= '0;
            run_o <= 1'b0;
        end else if (load_o) begin
            cnt_o <= '0;
            run_o <= 1'b1;
        end else begin
            cnt_o <= cnt_o + ONE;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |-> cnt_o < full_i);
    // R1
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> cnt_o == '0);
endmodule

// File: rtl/rgt_phase_fsm.sv
module rgt_phase_fsm
    import rgt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic [CNT_W-1:0] pa_end_i,
    input  logic [CNT_W-1:0] win_lo_i,
    input  logic [CNT_W-1:0] win_hi_i,
    output logic             pri_a_o,
    output logic             pri_b_o,
    output logic             sec_a_o,
    output logic             sec_b_o,
    output logic             frame_o
);
    rgt_state_e st_d, st_q;
    logic       frame_q;
    logic [CNT_W-1:0] pos;

    // next state from tick position within the half-period
    always_comb begin
        pos = (cnt_i >= half_i) ? cnt_i - half_i : cnt_i;
        if (!run_i) begin
            st_d = ST_IDLE;
        end else if (cnt_i < half_i) begin
            if      (pos < win_lo_i) st_d = ST_H1_PRE;
            else if (pos < win_hi_i) st_d = ST_H1_RECT;
            else if (pos < pa_end_i) st_d = ST_H1_POST;
            else                     st_d = ST_H1_DEAD;
        end else begin
            if      (pos < win_lo_i) st_d = ST_H2_PRE;
            else if (pos < win_hi_i) st_d = ST_H2_RECT;
            else if (pos < pa_end_i) st_d = ST_H2_POST;
            else                     st_d = ST_H2_DEAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            frame_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            frame_q <= run_i && (cnt_i == '0);
        end
    end

    always_comb begin
        pri_a_o = 1'b0;
        pri_b_o = 1'b0;
        sec_a_o = 1'b0;
        sec_b_o = 1'b0;
        frame_o = frame_q;
        unique case (st_q)
            ST_IDLE:    ;
            ST_H1_PRE, ST_H1_POST: begin
                pri_a_o = 1'b1; sec_a_o = 1'b1; sec_b_o = 1'b1;
            end
            ST_H1_RECT: begin
                pri_a_o = 1'b1; sec_a_o = 1'b1;
            end
            ST_H1_DEAD, ST_H2_DEAD: begin
                sec_a_o = 1'b1; sec_b_o = 1'b1;
            end
            ST_H2_PRE, ST_H2_POST: begin
                pri_b_o = 1'b1; sec_a_o = 1'b1; sec_b_o = 1'b1;
            end
            ST_H2_RECT: begin
                pri_b_o = 1'b1; sec_b_o = 1'b1;
            end
            default:    ;
        endcase
    end

    // R9
    rect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_H1_RECT) |=> (st_q inside {ST_H1_RECT, ST_H1_POST, ST_H1_DEAD, ST_IDLE}));
    // R9
    dead_to_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_H1_DEAD && st_d != ST_H1_DEAD && run_i) |-> (st_d inside {ST_H2_PRE, ST_H2_RECT}));
endmodule

// File: rtl/rgt_gate_timer.sv
module rgt_gate_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] dead_i,
    input  logic [CNT_W-1:0] son_i,
    input  logic [CNT_W-1:0] shift_i,
    output logic             gate_pri_a_o,
    output logic             gate_pri_b_o,
    output logic             gate_sec_a_o,
    output logic             gate_sec_b_o,
    output logic             frame_o
);
    logic [CNT_W-1:0] full, half, pa_end, win_lo, win_hi, cnt;
    logic             run, load;

    rgt_period_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .en(en), .full_i(full),
        .cnt_o(cnt), .run_o(run), .load_o(load)
    );

    rgt_cfg_limit #(.CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(run),
        .period_i(period_i), .dead_i(dead_i), .son_i(son_i), .shift_i(shift_i),
        .full_o(full), .half_o(half), .pa_end_o(pa_end),
        .win_lo_o(win_lo), .win_hi_o(win_hi)
    );

    rgt_phase_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .cnt_i(cnt),
        .half_i(half), .pa_end_i(pa_end), .win_lo_i(win_lo), .win_hi_i(win_hi),
        .pri_a_o(gate_pri_a_o), .pri_b_o(gate_pri_b_o),
        .sec_a_o(gate_sec_a_o), .sec_b_o(gate_sec_b_o), .frame_o(frame_o)
    );

    // R3
    pri_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pri_a_o && gate_pri_b_o));
    // R4
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_pri_b_o) |-> !$past(gate_pri_a_o));
    // R6
    sec_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_pri_a_o || gate_pri_b_o) |-> (gate_sec_a_o || gate_sec_b_o));
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |=> !(gate_pri_a_o || gate_pri_b_o || gate_sec_a_o || gate_sec_b_o || frame_o));
    // R7
    win_in_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_sec_b_o && gate_sec_a_o |-> gate_pri_a_o);
endmodule

// File: tb/rgt_gate_timer_tb_top.sv
module rgt_gate_timer_tb_top;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [CNT_W-1:0] period_i = 8'd200, dead_i = 8'd10, son_i = 8'd118, shift_i = 8'd20;
    logic pa, pb, sa, sb, fr;

    int checks = 0, failures = 0;
    logic [4:0] exp_q[$];
    bit mon_on = 1'b0;
    int tick_no = 0;
    string case_name = "";

    always #4 clk = ~clk;

    rgt_gate_timer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .period_i(period_i), .dead_i(dead_i), .son_i(son_i), .shift_i(shift_i),
        .gate_pri_a_o(pa), .gate_pri_b_o(pb), .gate_sec_a_o(sa), .gate_sec_b_o(sb),
        .frame_o(fr)
    );

    // clamping rules of R2, R4, R5, R7
    task automatic eval_cfg(input int per, dd, on, sh, output int h, d, w, s);
        h = per / 2; if (h < 4) h = 4;
        d = dd; if (d < 1) d = 1; if (d > h - 2) d = h - 2;
        w = (on >= 2 * h) ? 1 : 2 * h - on; if (w > h - d) w = h - d;
        s = sh; if (s < d) s = d; if (s > h - w) s = h - w;
    endtask

    // pattern of R2, R3, R5, R6; bits {frame, sec_b, sec_a, pri_b, pri_a}
    function automatic logic [4:0] exp_vec(int t, int h, int d, int w, int s);
        logic [4:0] v;
        v[0] = (t < h - d);
        v[1] = (t >= h) && (t < 2 * h - d);
        v[2] = !((t >= 2 * h - s - w) && (t < 2 * h - s));
        v[3] = !((t >= h - s - w) && (t < h - s));
        v[4] = (t == 0);
        return v;
    endfunction

    task automatic push_periods(input int per, dd, on, sh, input int n);
        int h, d, w, s;
        eval_cfg(per, dd, on, sh, h, d, w, s);
        for (int p = 0; p < n; p++)
            for (int t = 0; t < 2 * h; t++)
                exp_q.push_back(exp_vec(t, h, d, w, s));
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if ({fr, sb, sa, pb, pa} !== 5'b0) begin
            failures++;
            $display("FAIL %s idle outputs got %b exp 00000", tag, {fr, sb, sa, pb, pa});
        end
    endtask

    // driver: period 0 uses first settings; settings changed mid period 0 apply from period 1 (R8)
    task automatic run_case(input string nm, input int p1, d1, o1, s1,
                            input int p2, d2, o2, s2, input int n2);
        case_name = nm;
        tick_no = 0;
        push_periods(p1, d1, o1, s1, 1);
        push_periods(p2, d2, o2, s2, n2);
        @(negedge clk);
        period_i = CNT_W'(p1); dead_i = CNT_W'(d1); son_i = CNT_W'(o1); shift_i = CNT_W'(s1);
        en = 1'b1;
        @(posedge clk); @(posedge clk); #1 mon_on = 1'b1;
        repeat (20) @(negedge clk);
        period_i = CNT_W'(p2); dead_i = CNT_W'(d2); son_i = CNT_W'(o2); shift_i = CNT_W'(s2);
        wait (exp_q.size() == 0);
        #1 mon_on = 1'b0;
        en = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_idle("R1 after disable");
    endtask

    // monitor: compares each tick against the scoreboard queue
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            logic [4:0] e;
            e = exp_q.pop_front();
            checks++;
            if ({fr, sb, sa, pb, pa} !== e) begin
                failures++;
                $display("FAIL R2/R3/R5/R6/R9 case %s tick %0d got %b exp %b",
                         case_name, tick_no, {fr, sb, sa, pb, pa}, e);
            end
            tick_no++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R1 watchdog got hang exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 enable low");
        // nominal 0.59 duty, 10-tick dead, 20-tick shift
        run_case("nominal", 200, 10, 118, 20, 200, 10, 118, 20, 2);
        // R4: zero dead time clamps to one tick; R5: 0.5 duty shrinks window to H-d
        run_case("dead0_half", 200, 0, 100, 0, 200, 0, 100, 0, 1);
        // R7: oversized shift clamps to H-W, off window starts on tick 0
        run_case("bigshift", 200, 10, 126, 99, 200, 10, 126, 99, 1);
        // R8: all four settings change during period 0, new period length included
        run_case("midchange", 64, 3, 40, 5, 40, 2, 24, 6, 2);
        run_case("midchange_up", 48, 4, 30, 6, 200, 12, 126, 30, 1);
        // R5: on-time beyond the period gives a one-tick window; R1 restart from zero
        run_case("fullon", 60, 5, 255, 5, 60, 5, 255, 5, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule